// File: doc/BRIEF.md
# Inter-Processor Interrupt Register Block

This block lets processors on one chip signal each other through a small set of memory-mapped registers. Eleven request lines come in from other agents and latch into a sticky status word. A per-source mask, changed only through separate enable and disable registers, decides which latched requests reach a single combined interrupt output. Software acknowledges a request by writing ones to the status word.

In the other direction, a write to the trigger register sends a one-cycle pulse on the matching outbound trigger lines. The block also has eleven observation lines. The inputs can be read back through a register, and the outputs mirror the status word so other agents can see which requests are still pending.

The eleven sources occupy a sparse set of bit positions in every 32-bit register word:

| Source index | Bit position |
|---|---|
| 0 | 0 |
| 1, 2 | 8, 9 |
| 3 to 6 | 16 to 19 |
| 7 to 10 | 24 to 27 |

This gives a valid-bit mask of 0x0F0F0301. Every per-source pin is a compact 11-bit vector in source-index order.

The register interface is a plain strobe bus. Each access lasts one cycle with no back-pressure, and read data appears one cycle after the read strobe.

Top module: `ipi_regblock`

## Requirements
- R1: After reset the mask register reads 0x0F0F0301 and the status register reads zero. `irq`, `trig_out` and `obs_out` are all low.
- R2: Only the eleven valid bit positions are implemented. Other bits read zero and ignore writes, and any word outside the map (byte offsets 0x00 trigger, 0x04 observation, 0x10 status, 0x14 mask, 0x18 enable, 0x1C disable) reads zero.
- R3: A write to offset 0x00 drives `trig_out[i]` high for exactly the one cycle after the write for each valid bit set in the data. Reads of 0x00 return zero.
- R4: A high `req_in[i]` sets status bit i, and the bit stays set until software clears it.
- R5: Writing a one to a status bit at offset 0x10 clears it. Writing a zero leaves the bit unchanged.
- R6: When a clear and a new request for the same source land in the same cycle, the status bit ends up set.
- R7: Offset 0x14 is read-only. A one written to offset 0x18 clears the matching mask bit, and a one written to offset 0x1C sets it. Both 0x18 and 0x1C read zero.
- R8: `irq` is registered. It is high in the cycle after some status bit is set while its mask bit is clear.
- R9: A read of offset 0x04 returns the level of `obs_in[i]` at the bit position of source i.
- R10: `obs_out` equals the status word in compact order and changes in the same cycle as status.
- R11: An access whose byte enables are not all ones, or whose address is not word aligned, has no effect. As a read it returns zero.
- R12: `bus_rdata` holds the read value in the cycle after `bus_rd` and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address |
| bus_be | input | 4 | Byte enables, all ones for a legal access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| req_in | input | 11 | Inbound request per source |
| trig_out | output | 11 | Outbound one-cycle trigger per source |
| obs_in | input | 11 | Observation inputs |
| obs_out | output | 11 | Mirror of the status word |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The following are checked on every cycle:
- `trig_out` stays low unless a legal trigger write happened in the cycle before.
- An asserted request always shows up in `obs_out` one cycle later.
- `obs_out` holds steady when there is no request and no write.
- `irq` stays low while the mask is full or the previous status word was empty.
- Reads of the trigger word return zero.

The following can only be shown by the bench's scenarios:
- The exact read values of each register.
- Enable and disable editing the mask.
- Write-one-to-clear.
- Sparse bit placement of the observation inputs.
- Rejection of partial and unaligned accesses.
- The one-cycle lag of `irq` behind status and mask.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int NSRC   = 11;
  localparam int DATA_W = 32;

  // word indices (byte offset / 4)
  localparam int W_TRIG = 0;
  localparam int W_OBS  = 1;
  localparam int W_STAT = 4;
  localparam int W_MASK = 5;
  localparam int W_ENA  = 6;
  localparam int W_DIS  = 7;

  // bit position of compact source index i inside a register word
  function automatic int unsigned src_pos(input int unsigned i);
    if (i == 0)      return 0;
    else if (i < 3)  return i + 7;
    else if (i < 7)  return i + 13;
    else             return i + 17;
  endfunction

  function automatic logic [DATA_W-1:0] spread(input logic [NSRC-1:0] c);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < NSRC; i++) w[src_pos(i)] = c[i];
    return w;
  endfunction

  function automatic logic [NSRC-1:0] gather(input logic [DATA_W-1:0] w);
    logic [NSRC-1:0] c;
    for (int i = 0; i < NSRC; i++) c[i] = w[src_pos(i)];
    return c;
  endfunction

  localparam logic [DATA_W-1:0] VALID_BITS = spread({NSRC{1'b1}});
endpackage

// File: rtl/ipi_bus_decode.sv
module ipi_bus_decode
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic              wr,
  input  logic              rd,
  output logic              we_trig,
  output logic              we_stat,
  output logic              we_ena,
  output logic              we_dis,
  output logic              rd_go,
  output logic [ADDR_W-3:0] rd_word
);
  logic full;
  int   widx;

  assign full    = (be == 4'hF) && (addr[1:0] == 2'b00);
  assign rd_word = addr[ADDR_W-1:2];
  assign widx    = int'(addr[ADDR_W-1:2]);

  assign we_trig = wr && full && (widx == W_TRIG);
  assign we_stat = wr && full && (widx == W_STAT);
  assign we_ena  = wr && full && (widx == W_ENA);
  assign we_dis  = wr && full && (widx == W_DIS);
  assign rd_go   = rd && full;
endmodule

// File: rtl/ipi_trigger.sv
module ipi_trigger
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   trig_q
);
  // one-cycle pulse; returns to zero unless written again
  always_ff @(posedge clk) begin
    if (!rst_n)    trig_q <= '0;
    else if (fire) trig_q <= gather(wdata);
    else           trig_q <= '0;
  end
endmodule

// File: rtl/ipi_status_bank.sv
module ipi_status_bank
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_in,
  input  logic              clr_we,
  input  logic              ena_we,
  input  logic              dis_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   stat_q,
  output logic [NSRC-1:0]   mask_q,
  output logic              irq_q
);
  logic [NSRC-1:0] wbits, stat_d, mask_d;

  assign wbits = gather(wdata);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      // a new request beats a same-cycle clear
      if (req_in[i])                   stat_d[i] = 1'b1;
      else if (clr_we && wbits[i])     stat_d[i] = 1'b0;
      else                             stat_d[i] = stat_q[i];

      if (ena_we && wbits[i])          mask_d[i] = 1'b0;
      else if (dis_we && wbits[i])     mask_d[i] = 1'b1;
      else                             mask_d[i] = mask_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= |(stat_q & ~mask_q);
    end
  end
endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [ADDR_W-3:0] rd_word,
  input  logic [NSRC-1:0]   stat_q,
  input  logic [NSRC-1:0]   mask_q,
  input  logic [NSRC-1:0]   obs_in,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] val;

  always_comb begin
    case (int'(rd_word))
      W_OBS:   val = spread(obs_in);
      W_STAT:  val = spread(stat_q);
      W_MASK:  val = spread(mask_q);
      default: val = '0; // trigger, enable, disable and holes read zero
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_go) rdata_q <= val & VALID_BITS;
    else            rdata_q <= '0;
  end
endmodule

// File: rtl/ipi_regblock.sv
module ipi_regblock
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   req_in,
  output logic [NSRC-1:0]   trig_out,
  input  logic [NSRC-1:0]   obs_in,
  output logic [NSRC-1:0]   obs_out,
  output logic              irq
);
  logic              we_trig, we_stat, we_ena, we_dis, rd_go;
  logic [ADDR_W-3:0] rd_word;
  logic [NSRC-1:0]   stat_q, mask_q;

  ipi_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .be(bus_be), .wr(bus_wr), .rd(bus_rd),
    .we_trig(we_trig), .we_stat(we_stat), .we_ena(we_ena), .we_dis(we_dis),
    .rd_go(rd_go), .rd_word(rd_word)
  );

  ipi_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .fire(we_trig), .wdata(bus_wdata),
    .trig_q(trig_out)
  );

  ipi_status_bank u_bank (
    .clk(clk), .rst_n(rst_n), .req_in(req_in),
    .clr_we(we_stat), .ena_we(we_ena), .dis_we(we_dis), .wdata(bus_wdata),
    .stat_q(stat_q), .mask_q(mask_q), .irq_q(irq)
  );

  ipi_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_word(rd_word),
    .stat_q(stat_q), .mask_q(mask_q), .obs_in(obs_in), .rdata_q(bus_rdata)
  );

  assign obs_out = stat_q;
endmodule

// File: rtl/ipi_regblock_chk.sv
module ipi_regblock_chk
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NSRC-1:0]   req_in,
  input logic [NSRC-1:0]   trig_out,
  input logic [NSRC-1:0]   obs_out,
  input logic [NSRC-1:0]   mask_q,
  input logic              irq
);
  // R3
  trig_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == '0 && bus_be == 4'hF) |=> trig_out == '0);

  // R3
  trig_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == '0) |=> bus_rdata == '0);

  // R4
  req_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in != '0) |=> ((obs_out & $past(req_in)) == $past(req_in)));

  // R10
  obs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in == '0 && !bus_wr) |=> $stable(obs_out));

  // R8
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(obs_out) == '0) |-> !irq);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |=> !irq);
endmodule

bind ipi_regblock ipi_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_ipi_regblock.sv
`timescale 1ns/1ps
module tb_ipi_regblock;
  localparam logic [31:0] VM = 32'h0F0F0301;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] req_in = '0, obs_in = '0;
  logic [10:0] trig_out, obs_out;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipi_regblock dut (.*);

  // independent placement table for the sparse bit layout
  function automatic logic [31:0] sp(input logic [10:0] c);
    int p [11] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
    logic [31:0] w = '0;
    for (int i = 0; i < 11; i++) w[p[i]] = c[i];
    return w;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_req(input logic [10:0] c);
    @(negedge clk);
    req_in = c;
    @(negedge clk);
    req_in = '0;
  endtask

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read and compare, 2 request pulse
    logic [5:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 6'h14, 4'hF, 32'h0,        VM,           8'd1},  // R1 mask reset
    '{2'd1, 6'h10, 4'hF, 32'h0,        32'h0,        8'd1},  // R1 status reset
    '{2'd1, 6'h08, 4'hF, 32'h0,        32'h0,        8'd2},  // R2 hole reads zero
    '{2'd2, 6'h00, 4'h0, 32'h005,      32'h0,        8'd4},
    '{2'd1, 6'h10, 4'hF, 32'h0,        32'h201,      8'd4},  // R4 sticky latch
    '{2'd0, 6'h10, 4'hF, 32'h1,        32'h0,        8'd5},
    '{2'd1, 6'h10, 4'hF, 32'h0,        32'h200,      8'd5},  // R5 w1c
    '{2'd0, 6'h18, 4'hF, 32'h200,      32'h0,        8'd7},
    '{2'd1, 6'h14, 4'hF, 32'h0,        32'h0F0F0101, 8'd7},  // R7 enable
    '{2'd1, 6'h18, 4'hF, 32'h0,        32'h0,        8'd7},  // R7 enable reads 0
    '{2'd1, 6'h1C, 4'hF, 32'h0,        32'h0,        8'd7},  // R7 disable reads 0
    '{2'd0, 6'h1C, 4'hF, 32'h200,      32'h0,        8'd7},
    '{2'd1, 6'h14, 4'hF, 32'h0,        VM,           8'd7},  // R7 disable
    '{2'd0, 6'h14, 4'hF, 32'h0,        32'h0,        8'd7},
    '{2'd1, 6'h14, 4'hF, 32'h0,        VM,           8'd7},  // R7 read-only
    '{2'd0, 6'h10, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd5},
    '{2'd1, 6'h10, 4'hF, 32'h0,        32'h0,        8'd5},  // R5
    '{2'd0, 6'h18, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd7},
    '{2'd1, 6'h14, 4'hF, 32'h0,        32'h0,        8'd7},  // R7
    '{2'd0, 6'h1C, 4'hF, 32'hF0F0FCFE, 32'h0,        8'd2},
    '{2'd1, 6'h14, 4'hF, 32'h0,        32'h0,        8'd2},  // R2 invalid bits ignored
    '{2'd0, 6'h1C, 4'h3, 32'hFFFFFFFF, 32'h0,        8'd11},
    '{2'd1, 6'h14, 4'hF, 32'h0,        32'h0,        8'd11}, // R11 partial write
    '{2'd0, 6'h1D, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd11},
    '{2'd1, 6'h14, 4'hF, 32'h0,        32'h0,        8'd11}, // R11 unaligned write
    '{2'd1, 6'h00, 4'hF, 32'h0,        32'h0,        8'd3},  // R3 trigger reads 0
    '{2'd2, 6'h00, 4'h0, 32'h7FF,      32'h0,        8'd4},
    '{2'd1, 6'h10, 4'hF, 32'h0,        VM,           8'd4},  // R4 all sources
    '{2'd0, 6'h10, 4'hF, 32'hFFFFFFFF, 32'h0,        8'd5},
    '{2'd1, 6'h10, 4'hF, 32'h0,        32'h0,        8'd5}   // R5
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 trig_out", {21'b0, trig_out}, 32'h0);
    chk("R1 obs_out", {21'b0, obs_out}, 32'h0);
    rd(6'h14, 4'h3, d);
    chk("R11 partial read", d, 32'h0);
    chk("R12 idle rdata", bus_rdata, 32'h0);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k].op)
        2'd0: wr(VEC[k].addr, VEC[k].be, VEC[k].data);
        2'd1: begin
          rd(VEC[k].addr, VEC[k].be, d);
          chk($sformatf("R%0d vec %0d", VEC[k].rq, k), d, VEC[k].exp);
        end
        default: pulse_req(VEC[k].data[10:0]);
      endcase
    end

    // R3 trigger pulse width
    @(negedge clk);
    bus_addr = 6'h00; bus_be = 4'hF; bus_wdata = 32'hFFFFFFFF; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R3 pulse high", {21'b0, trig_out}, 32'h7FF);
    @(negedge clk);
    chk("R3 pulse low", {21'b0, trig_out}, 32'h0);
    wr(6'h00, 4'hF, 32'h00000100);
    chk("R3 single source", {21'b0, trig_out}, 32'h002);

    // R9 observation read
    obs_in = 11'h555;
    rd(6'h04, 4'hF, d);
    chk("R9 obs 555", d, sp(11'h555));
    obs_in = 11'h2AA;
    rd(6'h04, 4'hF, d);
    chk("R9 obs 2AA", d, sp(11'h2AA));

    // R8 / R10 irq timing (mask currently all clear)
    pulse_req(11'h008);
    chk("R10 obs_out mirror", {21'b0, obs_out}, 32'h008);
    chk("R8 irq lag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq set", {31'b0, irq}, 32'h1);
    wr(6'h1C, 4'hF, sp(11'h008));
    chk("R8 irq before mask takes effect", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);

    // R6 set wins over clear
    @(negedge clk);
    bus_addr = 6'h10; bus_be = 4'hF; bus_wdata = sp(11'h008); bus_wr = 1'b1;
    req_in = 11'h008;
    @(negedge clk);
    bus_wr = 1'b0; req_in = '0;
    chk("R6 set wins", {21'b0, obs_out}, 32'h008);
    wr(6'h10, 4'hF, sp(11'h008));
    chk("R10 obs_out cleared", {21'b0, obs_out}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule